// File: doc/BRIEF.md
# Untagged Direct-Mapped Branch Target Buffer

This block gives the fetch stage its next fetch address. A small direct-mapped array holds full target addresses of branches that were taken. The array is indexed by a few low bits of the word-aligned PC, and it stores no tags and no valid bits. Any PC that falls on a slot gets that slot's stored target, whichever branch wrote it.

On the fetch side the block takes the current PC and a taken/not-taken prediction from a separate direction predictor. A taken prediction selects the stored target as the next fetch address. A not-taken prediction selects the sequential address PC + 4. A flag reports which of the two was chosen. The lookup is purely combinational.

On the commit side, a resolved branch presents its own PC, its outcome and its resolved target. The slot is overwritten only when the branch was actually taken. Both ports are plain and always accepted. No back-pressure exists in either direction: the fetch result is valid in the same cycle as its inputs, and a commit beat is consumed on the clock edge where it is presented.

Top module: `btb_top`

## Requirements
- R1: After reset every slot holds 0, so a taken prediction for any PC yields next address 0 until that slot is written.
- R2: The slot number is bits [5:2] of the PC, i.e. (PC >> 2) mod 16; PC 0x0BC selects slot 15.
- R3: A commit beat with `cm_valid`=1 and `cm_taken`=1 writes `cm_target` into the slot of `cm_pc`, and the new value is visible to lookups from the next cycle on.
- R4: A commit beat with `cm_taken`=0, or any cycle with `cm_valid`=0, leaves every slot unchanged.
- R5: No tag is compared: two PCs whose bits [5:2] are equal return the same stored target.
- R6: With `fe_pred_taken`=0 the next address is `fe_pc` + 4 (modulo 2^64) and `fe_from_btb` is 0.
- R7: With `fe_pred_taken`=1 the next address is the stored target of the PC's slot and `fe_from_btb` is 1.
- R8: A lookup and a write to the same slot in the same cycle return the contents held before that write.
- R9: Slots are independent: a write to one slot does not change any other slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset, clears all slots |
| fe_pc | input | 64 | PC of the instruction being fetched |
| fe_pred_taken | input | 1 | Direction prediction for that instruction, 1 = taken |
| fe_next_pc | output | 64 | Next fetch address |
| fe_from_btb | output | 1 | 1 when the next address came from the buffer |
| cm_valid | input | 1 | A resolved branch is presented on the commit port |
| cm_pc | input | 64 | PC of the resolved branch |
| cm_taken | input | 1 | Actual outcome of the resolved branch |
| cm_target | input | 64 | Resolved target of the branch |

## Verification
The hardest case to reach is a lookup that lands on the very slot being written in the same edge: from the ports it looks the same as an ordinary lookup unless the stored value and the value being written differ. The stimulus first loads a known target into slot 15 and then, in one cycle, writes a different target there while fetching the same PC. The old value must appear, and the new one must appear in the cycle after. Aliasing is reached by fetching a PC that differs from the writer's PC only above bit 5. Sequential-address wrap is reached by fetching the top word of the address space with a not-taken prediction.

// File: rtl/btb_pkg.sv
package btb_pkg;
  // Default geometry of the buffer.
  localparam int unsigned BTB_ADDR_W = 64;  // address width
  localparam int unsigned BTB_IDX_W  = 4;   // slot index width
  localparam int unsigned BTB_ALIGN  = 2;   // instruction alignment, log2 bytes

  localparam int unsigned BTB_DEPTH = 1 << BTB_IDX_W;

  typedef logic [BTB_ADDR_W-1:0] btb_addr_t;
  typedef logic [BTB_IDX_W-1:0]  btb_idx_t;
endpackage

// File: rtl/btb_slot_sel.sv
// Maps a PC to a buffer slot: drop the alignment bits, keep the low index bits.
module btb_slot_sel #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned ALIGN  = 2
) (
  input  logic [ADDR_W-1:0] pc,
  output logic [IDX_W-1:0]  slot
);
  logic [ADDR_W-1:0] word_addr;

  always_comb begin
    word_addr = pc >> ALIGN;
    slot      = word_addr[IDX_W-1:0];
  end
endmodule

// File: rtl/btb_table.sv
// Storage array: one synchronous write port, one combinational read port.
// The read returns the contents held before any write in the same cycle.
module btb_table #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_slot,
  output logic [ADDR_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_slot,
  input  logic [ADDR_W-1:0] wr_data
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [ADDR_W-1:0] store [DEPTH];
  logic [DEPTH-1:0]  wr_hit;

  // One-hot write select, one bit per slot.
  for (genvar g = 0; g < DEPTH; g++) begin : g_dec
    assign wr_hit[g] = wr_en && (wr_slot == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n) begin
        store[i] <= '0;
      end else if (wr_hit[i]) begin
        store[i] <= wr_data;
      end
    end
  end

  assign rd_data = store[rd_slot];
endmodule

// File: rtl/btb_next_pc.sv
// Next-fetch-address select: buffer target when predicted taken, else sequential.
module btb_next_pc #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned ALIGN  = 2
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic              pred_taken,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] next_pc,
  output logic              from_btb
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN;

  always_comb begin
    if (pred_taken) begin
      next_pc  = target;
      from_btb = 1'b1;
    end else begin
      next_pc  = pc + STEP;
      from_btb = 1'b0;
    end
  end
endmodule

// File: rtl/btb_top.sv
module btb_top #(
  parameter int unsigned ADDR_W = btb_pkg::BTB_ADDR_W,
  parameter int unsigned IDX_W  = btb_pkg::BTB_IDX_W,
  parameter int unsigned ALIGN  = btb_pkg::BTB_ALIGN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fe_pc,
  input  logic              fe_pred_taken,
  output logic [ADDR_W-1:0] fe_next_pc,
  output logic              fe_from_btb,
  input  logic              cm_valid,
  input  logic [ADDR_W-1:0] cm_pc,
  input  logic              cm_taken,
  input  logic [ADDR_W-1:0] cm_target
);
  logic [IDX_W-1:0]  fe_slot;
  logic [IDX_W-1:0]  cm_slot;
  logic [ADDR_W-1:0] fe_target;
  logic              cm_write;

  // Only branches that really went taken leave a target behind.
  assign cm_write = cm_valid && cm_taken;

  btb_slot_sel #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN(ALIGN)) u_fe_sel (
    .pc   (fe_pc),
    .slot (fe_slot)
  );

  btb_slot_sel #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN(ALIGN)) u_cm_sel (
    .pc   (cm_pc),
    .slot (cm_slot)
  );

  btb_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_slot (fe_slot),
    .rd_data (fe_target),
    .wr_en   (cm_write),
    .wr_slot (cm_slot),
    .wr_data (cm_target)
  );

  btb_next_pc #(.ADDR_W(ADDR_W), .ALIGN(ALIGN)) u_mux (
    .pc         (fe_pc),
    .pred_taken (fe_pred_taken),
    .target     (fe_target),
    .next_pc    (fe_next_pc),
    .from_btb   (fe_from_btb)
  );
endmodule

// File: rtl/btb_top_chk.sv
module btb_top_chk #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned ALIGN  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] fe_pc,
  input logic              fe_pred_taken,
  input logic [ADDR_W-1:0] fe_next_pc,
  input logic              fe_from_btb,
  input logic              cm_valid,
  input logic [ADDR_W-1:0] cm_pc,
  input logic              cm_taken,
  input logic [ADDR_W-1:0] cm_target
);
  logic [ADDR_W-1:0] fe_word;
  logic [ADDR_W-1:0] cm_word;
  logic              same_slot;

  assign fe_word   = fe_pc >> ALIGN;
  assign cm_word   = cm_pc >> ALIGN;
  assign same_slot = fe_word[IDX_W-1:0] == cm_word[IDX_W-1:0];

  // R6: not-taken prediction gives the sequential address from the fetch side.
  assert_seq_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fe_pred_taken |-> (fe_next_pc == fe_pc + (ADDR_W'(1) << ALIGN)) && !fe_from_btb);

  // R7: taken prediction is always served by the buffer.
  assert_taken_uses_btb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fe_pred_taken |-> fe_from_btb);

  // R3, R8: a taken commit shows up at its own slot one cycle later, not earlier.
  assert_write_visible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && cm_taken && same_slot) ##1 (fe_pred_taken && $stable(fe_pc))
      |-> fe_next_pc == $past(cm_target));

  // R4: without a taken commit, a repeated taken lookup of one PC is stable.
  assert_no_spurious_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cm_valid && cm_taken) && fe_pred_taken) ##1 (fe_pred_taken && $stable(fe_pc))
      |-> $stable(fe_next_pc));
endmodule

bind btb_top btb_top_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN(ALIGN)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fe_pc         (fe_pc),
  .fe_pred_taken (fe_pred_taken),
  .fe_next_pc    (fe_next_pc),
  .fe_from_btb   (fe_from_btb),
  .cm_valid      (cm_valid),
  .cm_pc         (cm_pc),
  .cm_taken      (cm_taken),
  .cm_target     (cm_target)
);

// File: tb/btb_top_test.sv
`timescale 1ns/1ps
module btb_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] fe_pc = '0;
  logic        fe_pred_taken = 1'b0;
  logic [63:0] fe_next_pc;
  logic        fe_from_btb;
  logic        cm_valid = 1'b0;
  logic [63:0] cm_pc = '0;
  logic        cm_taken = 1'b0;
  logic [63:0] cm_target = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Bench-side model of the slots, built from the requirements.
  logic [63:0] model [16];

  logic [63:0] q_pc [$];
  bit          q_used [$];
  string       q_tag [$];

  always #4 clk = ~clk;  // 125 MHz

  btb_top uut (
    .clk(clk), .rst_n(rst_n), .fe_pc(fe_pc), .fe_pred_taken(fe_pred_taken),
    .fe_next_pc(fe_next_pc), .fe_from_btb(fe_from_btb), .cm_valid(cm_valid),
    .cm_pc(cm_pc), .cm_taken(cm_taken), .cm_target(cm_target)
  );

  function automatic int slot_of(logic [63:0] pc);
    return int'(pc[5:2]);  // R2
  endfunction

  // Driver: drive one cycle of stimulus and push the expected fetch result.
  task automatic cyc(input logic [63:0] pc, input bit pt, input bit cv,
                     input bit ct, input logic [63:0] cpc,
                     input logic [63:0] ctgt, input string tag);
    @(negedge clk);
    fe_pc = pc; fe_pred_taken = pt;
    cm_valid = cv; cm_taken = ct; cm_pc = cpc; cm_target = ctgt;
    q_pc.push_back(pt ? model[slot_of(pc)] : pc + 64'd4);
    q_used.push_back(pt);
    q_tag.push_back(tag);
    if (cv && ct) model[slot_of(cpc)] = ctgt;  // old value already queued (R8)
  endtask

  // Monitor: compare mid-cycle, after the inputs have settled.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (q_pc.size() != 0) begin
        logic [63:0] ep;
        bit eu;
        string t;
        ep = q_pc.pop_front();
        eu = q_used.pop_front();
        t  = q_tag.pop_front();
        checks++;
        if (fe_next_pc !== ep || fe_from_btb !== eu) begin
          failures++;
          $display("FAIL %s: next_pc=%h from_btb=%b expected next_pc=%h from_btb=%b",
                   t, fe_next_pc, fe_from_btb, ep, eu);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: every slot reads 0 after reset.
    for (int i = 0; i < 16; i++)
      cyc(64'h4000 + 64'(i * 4), 1'b1, 1'b0, 1'b0, '0, '0, "R1 reset slot");

    // R8: write slot 15 while reading it: old value 0 returned.
    cyc(64'h0BC, 1'b1, 1'b1, 1'b1, 64'h0BC, 64'h1000, "R8 same-cycle old value");
    // R3, R2: PC 0x0BC lands in slot 15 and sees the written target.
    cyc(64'h0BC, 1'b1, 1'b0, 1'b0, '0, '0, "R3 R2 write visible slot 15");
    // R8 again with a different value in the slot.
    cyc(64'h0BC, 1'b1, 1'b1, 1'b1, 64'h0BC, 64'h2220, "R8 overwrite returns 0x1000");
    cyc(64'h0BC, 1'b1, 1'b0, 1'b0, '0, '0, "R3 overwrite visible");
    // R5: alias with equal bits [5:2].
    cyc(64'hFFFF_0000_0000_03FC, 1'b1, 1'b0, 1'b0, '0, '0, "R5 alias slot 15");
    // R4: not-taken commit and invalid commit do not write.
    cyc(64'h0BC, 1'b1, 1'b1, 1'b0, 64'h0BC, 64'hDEAD_0000, "R4 not-taken commit");
    cyc(64'h0BC, 1'b1, 1'b0, 1'b1, 64'h0BC, 64'hBEEF_0000, "R4 invalid commit");
    cyc(64'h0BC, 1'b1, 1'b0, 1'b0, '0, '0, "R4 slot unchanged");
    // R6: sequential path, including wrap at the top of the space.
    cyc(64'h0BC, 1'b0, 1'b0, 1'b0, '0, '0, "R6 sequential");
    cyc(64'hFFFF_FFFF_FFFF_FFFC, 1'b0, 1'b0, 1'b0, '0, '0, "R6 wrap");
    // R9: fill slots 0..14 with distinct targets, then read them all.
    for (int i = 0; i < 15; i++)
      cyc(64'h0, 1'b0, 1'b1, 1'b1, 64'h8000 + 64'(i * 4),
          64'hA000_0000 + 64'(i * 64'h111), "R9 fill");
    for (int i = 0; i < 16; i++)
      cyc(64'h100 + 64'(i * 4), 1'b1, 1'b0, 1'b0, '0, '0, "R9 R7 slot readback");
    // R7: taken lookup reports the buffer path.
    cyc(64'h0C0, 1'b1, 1'b0, 1'b0, '0, '0, "R7 taken slot 0");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule